// File: doc/BRIEF.md
# Read Latency Data Pipeline

This block sits on the output side of a synchronous DRAM data path. Read beats arriving from the storage array are delayed by a run-time selectable read latency of two or three clocks before they appear on an 8-bit data bus with an output-enable. A per-cycle mask input blanks individual output beats during reads after a fixed two-clock delay. On the write side, the same mask drops an incoming beat in the very cycle it is presented. A precharge command closes the current read so that the bus falls to high impedance after exactly the read latency.

A read command opens a read and may arrive on any cycle, including in the middle of a running burst. The array keeps presenting beats, and the new stream follows the old one on the bus with no gap, at the current latency. The latency setting is only taken over on an edge where no accepted beat is still waiting to reach the bus, so beats already in flight keep their alignment. Storage, refresh and command decoding live elsewhere.

Top module: `rd_latency_pipe`

## Requirements
- R1: While `rstN` is low, `dqOe` and `dqOut` are 0 and no read is open. After reset is released, array beats presented without a read command are not driven onto the bus.
- R2: With latency two, a beat accepted at clock edge k is driven, with `dqOe` high and `dqOut` equal to its data, in the clock period that begins at edge k+1.
- R3: With latency three, a beat accepted at clock edge k is driven in the clock period that begins at edge k+2.
- R4: `latSel` value 0 selects latency two and value 1 selects latency three. The setting is taken over at an edge only if no beat was accepted at either of the two preceding edges. Otherwise the current latency is kept.
- R5: A beat on `arrValid` is accepted when `rdIssue` is high in the same cycle, or when a read is open and `preCharge` is low. `rdIssue` opens a read. `preCharge` without `rdIssue` closes it.
- R6: A read command that arrives while a burst is running interrupts it. The beats continue on the bus in consecutive periods with no idle period at the changeover.
- R7: `dqMask` sampled high at edge m forces `dqOe` low in the period that begins at edge m+1, at either latency. The masked beat is dropped and later beats keep their timing.
- R8: After `preCharge` is sampled at edge p, beats accepted before p are still driven. `dqOe` is low from the period that begins at edge p+L-1, where L is the latency, until a beat of a new read arrives.
- R9: `wrStrobe` equals `wrBeat` AND NOT `dqMask` in the same cycle with no clock delay, and `wrDataOut` follows `wrData`.
- R10: `dqOut` is 0 in every period in which `dqOe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rdIssue | input | 1 | Read command strobe; opens or restarts a read |
| preCharge | input | 1 | Precharge command strobe; closes the open read |
| latSel | input | 1 | Latency request: 0 selects two clocks, 1 selects three |
| dqMask | input | 1 | Per-cycle mask for read output and write input |
| arrValid | input | 1 | A read beat from the array is present this cycle |
| arrData | input | 8 | Read beat data from the array |
| wrBeat | input | 1 | A write beat is present this cycle |
| wrData | input | 8 | Write beat data |
| dqOut | output | 8 | Output bus data, 0 when not driven |
| dqOe | output | 1 | Output enable of the bus |
| wrStrobe | output | 1 | Write beat accepted toward the array |
| wrDataOut | output | 8 | Write data toward the array |

## Verification
Two cut-offs can fall on the same bus period: the two-clock mask blanking and the precharge cut-off at the read latency. The bench provokes this with a latency-three burst. It issues precharge at one edge and the mask at the next, so both target the same period. The bench expects a single blanked period with no beat leaking on either side. It also lands a mask on an interrupted stream and attempts latency changes in the middle of a burst, and judges each period against a schedule of expected beats built from the requirements.

// File: rtl/rlp_pkg.sv
package rlp_pkg;
  // Strobes handed from the control half to the datapath half
  typedef struct packed {
    logic accept;    // array beat enters the pipeline this cycle
    logic latThree;  // current latency is the longer setting
    logic blank;     // force the bus off in this period
    logic wrKeep;    // write beat of this cycle passes
  } ctl_strb_t;
endpackage

// File: rtl/rlp_ctrl.sv
module rlp_ctrl
  import rlp_pkg::*;
#(
  parameter int MASK_DLY = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdIssue,
  input  logic      preCharge,
  input  logic      latSel,
  input  logic      dqMask,
  input  logic      arrValid,
  input  logic      pipeBusy,
  output ctl_strb_t strb
);
  localparam int MSB = MASK_DLY - 1;

  logic           closedQ;
  logic           latThreeQ;
  logic [MSB:0]   mskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      closedQ   <= 1'b1;
      latThreeQ <= 1'b0;
    end else begin
      if (rdIssue)        closedQ <= 1'b0;
      else if (preCharge) closedQ <= 1'b1;
      if (!pipeBusy)      latThreeQ <= latSel;
    end
  end

  generate
    if (MASK_DLY == 1) begin : g_mskOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) mskQ <= '0;
        else       mskQ <= dqMask;
      end
    end else begin : g_mskShift
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) mskQ <= '0;
        else       mskQ <= {mskQ[MSB-1:0], dqMask};
      end
    end
  endgenerate

  always_comb begin
    strb.accept   = arrValid & (rdIssue | (~closedQ & ~preCharge));
    strb.latThree = latThreeQ;
    strb.blank    = mskQ[MSB];
    strb.wrKeep   = ~dqMask;
  end

  // R4
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pipeBusy |=> $stable(latThreeQ));

  // R5
  closed_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (preCharge && !rdIssue) ##1 !rdIssue |-> !strb.accept);
endmodule

// File: rtl/rlp_data.sv
module rlp_data
  import rlp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LAT_LO = 2,
  parameter int DEPTH  = LAT_LO + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strb_t         strb,
  input  logic [DATA_W-1:0] arrData,
  input  logic              wrBeat,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic              wrStrobe,
  output logic [DATA_W-1:0] wrDataOut,
  output logic              pipeBusy
);
  localparam int                IW     = $clog2(DEPTH);
  localparam logic [IW-1:0]     TAP_LO = IW'(LAT_LO - 1);
  localparam logic [IW-1:0]     TAP_HI = IW'(DEPTH - 1);

  logic [DEPTH-1:0]  stV;
  logic [DATA_W-1:0] stD [DEPTH];
  logic [IW-1:0]     tapIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stV <= '0;
      for (int i = 0; i < DEPTH; i++) stD[i] <= '0;
    end else begin
      stV <= {stV[DEPTH-2:0], strb.accept};
      if (strb.accept) stD[0] <= arrData;
      for (int i = 1; i < DEPTH; i++) stD[i] <= stD[i-1];
    end
  end

  always_comb begin
    tapIdx    = strb.latThree ? TAP_HI : TAP_LO;
    dqOe      = stV[tapIdx] & ~strb.blank;
    dqOut     = dqOe ? stD[tapIdx] : '0;
    pipeBusy  = |stV[LAT_LO-1:0];
    wrStrobe  = wrBeat & strb.wrKeep;
    wrDataOut = wrData;
  end

  // R2
  lat_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept && !strb.latThree && pipeBusy |-> ##2 (strb.blank || dqOe));

  // R3
  lat_three_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept && strb.latThree && pipeBusy |-> ##3 (strb.blank || dqOe));
endmodule

// File: rtl/rd_latency_pipe.sv
module rd_latency_pipe
  import rlp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LAT_LO   = 2,
  parameter int MASK_DLY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdIssue,
  input  logic              preCharge,
  input  logic              latSel,
  input  logic              dqMask,
  input  logic              arrValid,
  input  logic [DATA_W-1:0] arrData,
  input  logic              wrBeat,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic              wrStrobe,
  output logic [DATA_W-1:0] wrDataOut
);
  localparam int DEPTH = LAT_LO + 1;

  ctl_strb_t strb;
  logic      pipeBusy;

  rlp_ctrl #(.MASK_DLY(MASK_DLY)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdIssue  (rdIssue),
    .preCharge(preCharge),
    .latSel   (latSel),
    .dqMask   (dqMask),
    .arrValid (arrValid),
    .pipeBusy (pipeBusy),
    .strb     (strb)
  );

  rlp_data #(.DATA_W(DATA_W), .LAT_LO(LAT_LO), .DEPTH(DEPTH)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .arrData  (arrData),
    .wrBeat   (wrBeat),
    .wrData   (wrData),
    .dqOut    (dqOut),
    .dqOe     (dqOe),
    .wrStrobe (wrStrobe),
    .wrDataOut(wrDataOut),
    .pipeBusy (pipeBusy)
  );

  // R7
  mask_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqMask |-> ##2 !dqOe);

  // R8
  precharge_cut_chk: assert property (@(posedge clk) disable iff (!rstN)
    preCharge && !rdIssue && !strb.latThree && !latSel |-> ##2 !dqOe);

  // R9
  write_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqMask |-> !wrStrobe);
endmodule

// File: tb/rd_latency_pipe_tb.sv
module rd_latency_pipe_tb;
  localparam int DW   = 8;
  localparam int VW   = 18;
  localparam int NV   = 59;
  localparam int MAXC = 512;

  // vector: {tag[3:0], rd, pre, lat, msk, av, wb, data[7:0]}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd2, 6'b100010, 8'hA1}, {4'd2, 6'b000010, 8'hA2}, {4'd2, 6'b000010, 8'hA3},
    {4'd2, 6'b000010, 8'hA4}, {4'd2, 6'b000000, 8'h00},
    {4'd5, 6'b000010, 8'h55}, {4'd8, 6'b010000, 8'h00}, {4'd5, 6'b000010, 8'h66},
    {4'd0, 6'b000000, 8'h00},
    {4'd6, 6'b100010, 8'hB1}, {4'd6, 6'b000010, 8'hB2}, {4'd6, 6'b100010, 8'hC1},
    {4'd6, 6'b000010, 8'hC2}, {4'd6, 6'b100010, 8'hD1}, {4'd6, 6'b100010, 8'hD2},
    {4'd8, 6'b010000, 8'h00}, {4'd0, 6'b000000, 8'h00},
    {4'd7, 6'b100010, 8'hE1}, {4'd7, 6'b000110, 8'hE2}, {4'd7, 6'b000010, 8'hE3},
    {4'd7, 6'b000010, 8'hE4}, {4'd8, 6'b010000, 8'h00},
    {4'd8, 6'b100010, 8'hF1}, {4'd8, 6'b000010, 8'hF2}, {4'd8, 6'b010010, 8'hF3},
    {4'd8, 6'b000010, 8'hF4}, {4'd0, 6'b000000, 8'h00},
    {4'd4, 6'b100010, 8'h71}, {4'd4, 6'b001010, 8'h72}, {4'd4, 6'b001010, 8'h73},
    {4'd4, 6'b011000, 8'h00}, {4'd4, 6'b001000, 8'h00}, {4'd4, 6'b001000, 8'h00},
    {4'd3, 6'b101010, 8'h81}, {4'd3, 6'b001010, 8'h82}, {4'd3, 6'b001110, 8'h83},
    {4'd3, 6'b001010, 8'h84}, {4'd3, 6'b011000, 8'h00}, {4'd3, 6'b001010, 8'h85},
    {4'd3, 6'b001000, 8'h00},
    {4'd6, 6'b101010, 8'h91}, {4'd6, 6'b101010, 8'h92}, {4'd6, 6'b001010, 8'h93},
    {4'd6, 6'b011000, 8'h00}, {4'd7, 6'b001100, 8'h00}, {4'd3, 6'b001000, 8'h00},
    {4'd4, 6'b100010, 8'hC7}, {4'd4, 6'b000010, 8'hC8},
    {4'd9, 6'b000101, 8'h31}, {4'd9, 6'b000001, 8'h32}, {4'd9, 6'b010001, 8'h33},
    {4'd7, 6'b000100, 8'h00},
    {4'd3, 6'b101010, 8'hD7}, {4'd3, 6'b001010, 8'hD8}, {4'd3, 6'b011000, 8'h00},
    {4'd7, 6'b001100, 8'h00}, {4'd0, 6'b001000, 8'h00}, {4'd0, 6'b001000, 8'h00},
    {4'd0, 6'b001000, 8'h00}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rstN, rdIssue, preCharge, latSel, dqMask, arrValid, wrBeat;
  logic [DW-1:0] arrData, wrData, dqOut, wrDataOut;
  logic          dqOe, wrStrobe;

  rd_latency_pipe u_dut (
    .clk(clk), .rstN(rstN), .rdIssue(rdIssue), .preCharge(preCharge),
    .latSel(latSel), .dqMask(dqMask), .arrValid(arrValid), .arrData(arrData),
    .wrBeat(wrBeat), .wrData(wrData), .dqOut(dqOut), .dqOe(dqOe),
    .wrStrobe(wrStrobe), .wrDataOut(wrDataOut)
  );

  int nChk = 0, nBad = 0;
  bit done = 0;

  bit            expOeA [MAXC];
  logic [DW-1:0] expDA  [MAXC];
  int            expLA  [MAXC];
  bit            blankA [MAXC];
  int            cyc = 0, lastAcc = -10, mLat = 2;
  bit            mOpen = 0;

  function automatic string reqName(int n);
    case (n)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10";
      default: return "stream";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  task automatic idleInputs();
    rdIssue = 0; preCharge = 0; dqMask = 0; arrValid = 0; wrBeat = 0;
    arrData = '0; wrData = '0;
  endtask

  // Drive one cycle (called at a falling edge), advance, check at next falling edge
  task automatic runCycle(logic [VW-1:0] v);
    int   tag;
    bit   rd, pre, lat, msk, av, wb, busy, acc, expOe, expWr;
    logic [DW-1:0] d, expD;
    string oeReq;
    tag = int'(v[17:14]);
    {rd, pre, lat, msk, av, wb} = v[13:8];
    d = v[7:0];
    rdIssue = rd; preCharge = pre; latSel = lat; dqMask = msk;
    arrValid = av; arrData = d; wrBeat = wb; wrData = d ^ 8'h5A;
    // reference schedule built from the requirements
    busy = (cyc - lastAcc >= 1) && (cyc - lastAcc <= 2);        // R4
    if (!busy) mLat = lat ? 3 : 2;
    acc = av && (rd || (mOpen && !pre));                        // R5
    if (rd) mOpen = 1; else if (pre) mOpen = 0;
    if (acc) begin
      expOeA[cyc + mLat - 1] = 1;
      expDA[cyc + mLat - 1]  = d;
      expLA[cyc + mLat - 1]  = mLat;
      lastAcc = cyc;
    end
    if (msk) blankA[cyc + 1] = 1;                               // R7
    expWr = wb && !msk;
    @(posedge clk);
    @(negedge clk);
    expOe = expOeA[cyc] && !blankA[cyc];
    expD  = expOe ? expDA[cyc] : '0;
    if (blankA[cyc])      oeReq = "R7";
    else if (expOeA[cyc]) oeReq = (expLA[cyc] == 3) ? "R3" : "R2";
    else                  oeReq = "R8";
    chk(dqOe == expOe, oeReq, {"dqOe vec ", reqName(tag)}, int'(dqOe), int'(expOe));
    chk(dqOut == expD, expOe ? oeReq : "R10", {"dqOut vec ", reqName(tag)},
        int'(dqOut), int'(expD));
    chk(wrStrobe == expWr, "R9", "wrStrobe", int'(wrStrobe), int'(expWr));
    chk(wrDataOut == (d ^ 8'h5A), "R9", "wrDataOut", int'(wrDataOut), int'(d ^ 8'h5A));
    cyc++;
  endtask

  task automatic modelReset();
    mOpen = 0; lastAcc = -10; mLat = 2;
    for (int i = cyc; i < MAXC; i++) begin
      expOeA[i] = 0; blankA[i] = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < MAXC; i++) begin
      expOeA[i] = 0; expDA[i] = '0; expLA[i] = 2; blankA[i] = 0;
    end
    rstN = 0; latSel = 0;
    idleInputs();
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(dqOe == 1'b0, "R1", "dqOe in reset", int'(dqOe), 0);
      chk(dqOut == '0, "R1", "dqOut in reset", int'(dqOut), 0);
    end
    rstN = 1;
    // R1, R5: beat without a read command after reset is ignored
    runCycle({4'd1, 6'b000010, 8'hEE});
    runCycle({4'd1, 6'b000000, 8'h00});
    runCycle({4'd1, 6'b000000, 8'h00});
    // main table: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) runCycle(VEC[i]);
    // R1: reset in the middle of a burst clears the bus at once
    runCycle({4'd2, 6'b100010, 8'h11});
    runCycle({4'd2, 6'b000010, 8'h12});
    rstN = 0;
    idleInputs();
    #1;
    chk(dqOe == 1'b0, "R1", "dqOe after mid-burst reset", int'(dqOe), 0);
    chk(dqOut == '0, "R1", "dqOut after mid-burst reset", int'(dqOut), 0);
    @(negedge clk);
    @(negedge clk);
    chk(dqOe == 1'b0, "R1", "dqOe held in reset", int'(dqOe), 0);
    rstN = 1;
    modelReset();
    // R5: no open read after reset, beats are dropped
    runCycle({4'd5, 6'b000010, 8'h21});
    runCycle({4'd5, 6'b000010, 8'h22});
    runCycle({4'd5, 6'b000000, 8'h00});
    runCycle({4'd5, 6'b000000, 8'h00});
    // R6: interrupt with mask on first beat of the new stream at latency 2
    runCycle({4'd6, 6'b100010, 8'h41});
    runCycle({4'd6, 6'b100010, 8'h42});
    runCycle({4'd7, 6'b000010, 8'h43});
    runCycle({4'd6, 6'b010000, 8'h00});
    runCycle({4'd0, 6'b000000, 8'h00});
    runCycle({4'd0, 6'b000000, 8'h00});
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule